// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a system read a serial NOR flash as if it were ordinary memory. A client puts a byte address on a valid/ready read port. The engine then drives one complete flash read sequence on the serial pins: chip select goes low, then the opcode, the address bytes and a configurable number of dummy clocks, and finally the data phase. It returns the assembled 32-bit word as a one-cycle response pulse.

The shape of the sequence comes from a single 32-bit setup word. That word gives the opcode, the number of address bytes, the dummy length and whether the data phase uses one or four lines. A separate port-select input decides who owns the serial pins. When it is high, the mapped engine owns them and accepts requests. When it is low, the pins belong to a register-commanded engine elsewhere, and requests wait. The serial clock runs at half the system clock, with idle-low polarity and sampling on the rising edge.

Top module: `mmflash_read_engine`

## Requirements
- R1: While `cfg_map_sel` is 0, `req_ready` stays 0 and no request is accepted; a pending request is accepted once `cfg_map_sel` becomes 1 and the engine is idle.
- R2: The first 8 serial clocks of a sequence carry `cfg_setup[7:0]` on `spi_io_out[0]`, most significant bit first.
- R3: The address phase sends `cfg_setup[9:8]+1` bytes on `spi_io_out[0]`: the low bytes of the zero-extended request address, most significant byte and bit first (field value 2 gives three bytes).
- R4: Between address and data there are `8*cfg_setup[11:10] + cfg_setup[28:24]` dummy clocks, so a whole sequence has 8 + 8*(address bytes) + dummy + data clocks.
- R5: When `cfg_setup[13:12]` is 3, the data phase takes 8 clocks with one nibble per clock read from `spi_io_in[3:0]`, and `spi_io_oe` is 0. For any other value it takes 32 clocks with one bit per clock from `spi_io_in[1]`, and `spi_io_oe` is 4'b0001.
- R6: Received bytes are packed little-endian: the first byte goes to `rsp_data[7:0]`. Within a byte the first bit, or in quad mode the first nibble, is the most significant.
- R7: `spi_cs_n` falls in the cycle after a request is accepted and rises after the last data clock. `rsp_valid` is a single-cycle pulse while `spi_cs_n` is high.
- R8: The setup word is captured when a request is accepted; changing `cfg_setup` during a sequence has no effect on that sequence.
- R9: `port_owned` equals `cfg_map_sel` OR a sequence in progress; clearing `cfg_map_sel` mid-sequence lets the sequence finish.
- R10: `spi_sclk` is low whenever `spi_cs_n` is high, and `spi_io_oe` is 0 then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | 32 | Read framing setup word |
| cfg_map_sel | input | 1 | 1 hands the serial pins to this engine |
| req_valid | input | 1 | Read request valid |
| req_addr | input | ADDR_W | Byte address of the word |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle pulse with returned word |
| rsp_data | output | 32 | Returned word |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_out | output | 4 | Serial data out, line 0 is the single-line output |
| spi_io_oe | output | 4 | Output enables per data line |
| spi_io_in | input | 4 | Serial data in, line 1 is the single-line input |
| port_owned | output | 1 | Engine holds the serial pins |

## Verification
Reads run through a behavioural flash model under many random setup words: random opcodes, address byte counts 1 to 4, all dummy field values and extra dummy counts, and single or quad data. Each read checks the captured opcode and address bits (R2, R3), the serial clock count (R4) and the returned word (R5, R6). Directed cases cover three things: a request waiting while the port belongs to the register engine, a setup change in the middle of a sequence to show the snapshot, and the switch being cleared mid-sequence to show the sequence finishes while ownership is held. Output-enable monitoring tells single-line data phases apart from quad ones.

// File: rtl/mmfr_pkg.sv
package mmfr_pkg;
   // Longest sequence: 8 opcode + 32 address + 55 dummy + 32 data = 127 clocks
   localparam int CNT_W  = 7;
   localparam int WORD_W = 32;
   localparam int HDR_W  = 40;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SHIFT = 2'd1,
      SQ_DONE  = 2'd2
   } seq_state_t;

   typedef struct packed {
      logic [7:0] opcode;
      logic [2:0] addr_bytes;
      logic [5:0] dummy_clks;
      logic       quad;
   } rd_frame_t;
endpackage

// File: rtl/mmfr_frame_decode.sv
module mmfr_frame_decode
   import mmfr_pkg::*;
#(
   parameter bit QUAD_EN = 1'b1
) (
   input  logic [31:0]      setup,
   output rd_frame_t        frame,
   output logic [CNT_W-1:0] data_start,
   output logic [CNT_W-1:0] total_clks
);
   logic [CNT_W-1:0] hdr_clks;
   logic             unused_setup;

   assign frame.opcode     = setup[7:0];
   assign frame.addr_bytes = {1'b0, setup[9:8]} + 3'd1;
   assign frame.dummy_clks = {1'b0, setup[11:10], 3'b000} + {1'b0, setup[28:24]};
   assign frame.quad       = QUAD_EN && (setup[13:12] == 2'b11);

   assign hdr_clks   = CNT_W'(8) + CNT_W'({frame.addr_bytes, 3'b000});
   assign data_start = hdr_clks + CNT_W'(frame.dummy_clks);
   assign total_clks = data_start + (frame.quad ? CNT_W'(8) : CNT_W'(32));

   // Write opcode and reserved bits play no part in mapped reads
   assign unused_setup = ^{setup[31:29], setup[23:14]};
endmodule

// File: rtl/mmfr_seq.sv
module mmfr_seq
   import mmfr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] total_clks,
   input  logic [CNT_W-1:0] data_start,
   output logic             busy,
   output logic             done,
   output logic             sclk,
   output logic             cs_n,
   output logic             advance,
   output logic             in_data
);
   seq_state_t       state;
   logic [CNT_W-1:0] idx;
   logic             ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         idx   <= '0;
         ph    <= 1'b0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  state <= SQ_SHIFT;
                  idx   <= '0;
                  ph    <= 1'b0;
               end
            end
            SQ_SHIFT: begin
               ph <= ~ph;
               if (ph) begin
                  if (idx == total_clks - 1'b1) state <= SQ_DONE;
                  else                          idx   <= idx + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = (state != SQ_IDLE);
   assign done    = (state == SQ_DONE);
   assign cs_n    = (state != SQ_SHIFT);
   assign sclk    = (state == SQ_SHIFT) && ph;
   assign advance = (state == SQ_SHIFT) && ph;
   assign in_data = (state == SQ_SHIFT) && (idx >= data_start);
endmodule

// File: rtl/mmfr_rx_assemble.sv
module mmfr_rx_assemble
   import mmfr_pkg::*;
#(
   parameter bit QUAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic              quad,
   input  logic [3:0]        io_in,
   output logic [WORD_W-1:0] word
);
   localparam int NBYTES = WORD_W / 8;

   logic [WORD_W-1:0] raw;
   logic [WORD_W-1:0] raw_nxt;

   generate
      if (QUAD_EN) begin : g_quad
         assign raw_nxt = quad ? {raw[WORD_W-5:0], io_in}
                               : {raw[WORD_W-2:0], io_in[1]};
      end else begin : g_single
         logic unused_lines;
         assign unused_lines = ^{io_in[3:2], io_in[0], quad};
         assign raw_nxt = {raw[WORD_W-2:0], io_in[1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw <= '0;
      else if (clear)   raw <= '0;
      else if (capture) raw <= raw_nxt;
   end

   // First received byte sits at the top of raw; it belongs in the lowest lane
   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_swap
         assign word[8*b +: 8] = raw[8*(NBYTES-1-b) +: 8];
      end
   endgenerate
endmodule

// File: rtl/mmflash_read_engine.sv
module mmflash_read_engine
   import mmfr_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter bit QUAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_setup,
   input  logic              cfg_map_sel,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [31:0]       rsp_data,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic [3:0]        spi_io_out,
   output logic [3:0]        spi_io_oe,
   input  logic [3:0]        spi_io_in,
   output logic              port_owned
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("mmflash_read_engine: ADDR_W must lie in 8..32");
      end
   endgenerate

   logic             start, busy, done, advance, in_data;
   logic [31:0]      setup_q, dec_in;
   rd_frame_t        frame;
   logic [CNT_W-1:0] data_start, total_clks;
   logic [HDR_W-1:0] hdr_sr;
   logic [31:0]      addr_ext, addr_aligned;
   logic [5:0]       addr_shift;

   assign req_ready = !busy && cfg_map_sel;
   assign start     = req_valid && req_ready;

   // Live setup at acceptance, snapshot for the rest of the sequence
   assign dec_in = start ? cfg_setup : setup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     setup_q <= '0;
      else if (start) setup_q <= cfg_setup;
   end

   mmfr_frame_decode #(.QUAD_EN(QUAD_EN)) u_dec (
      .setup      (dec_in),
      .frame      (frame),
      .data_start (data_start),
      .total_clks (total_clks)
   );

   mmfr_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .total_clks (total_clks),
      .data_start (data_start),
      .busy       (busy),
      .done       (done),
      .sclk       (spi_sclk),
      .cs_n       (spi_cs_n),
      .advance    (advance),
      .in_data    (in_data)
   );

   // Header: opcode then the used address bytes left-aligned below it
   assign addr_ext     = 32'(req_addr);
   assign addr_shift   = {3'd4 - frame.addr_bytes, 3'b000};
   assign addr_aligned = addr_ext << addr_shift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hdr_sr <= '0;
      else if (start)   hdr_sr <= {frame.opcode, addr_aligned};
      else if (advance) hdr_sr <= {hdr_sr[HDR_W-2:0], 1'b0};
   end

   mmfr_rx_assemble #(.QUAD_EN(QUAD_EN)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .capture (advance && in_data),
      .quad    (frame.quad),
      .io_in   (spi_io_in),
      .word    (rsp_data)
   );

   assign spi_io_out = {3'b000, !spi_cs_n && hdr_sr[HDR_W-1]};
   assign spi_io_oe  = spi_cs_n                 ? 4'b0000 :
                       (in_data && frame.quad)  ? 4'b0000 : 4'b0001;
   assign rsp_valid  = done;
   assign port_owned = cfg_map_sel || busy;
endmodule

// File: rtl/mmfr_checker.sv
module mmfr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_map_sel,
   input logic       req_valid,
   input logic       req_ready,
   input logic       rsp_valid,
   input logic       spi_sclk,
   input logic       spi_cs_n,
   input logic [3:0] spi_io_oe,
   input logic       port_owned
);
   assert_no_accept_unmapped_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_map_sel && !port_owned |-> !req_ready);

   assert_cs_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> $past(req_valid && req_ready));

   assert_rsp_cs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> spi_cs_n);

   assert_rsp_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_owned_while_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> port_owned);

   assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> (!spi_sclk && spi_io_oe == 4'b0000));

   assert_oe_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(spi_io_oe));
endmodule

bind mmflash_read_engine mmfr_checker u_mmfr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_map_sel (cfg_map_sel),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .spi_sclk    (spi_sclk),
   .spi_cs_n    (spi_cs_n),
   .spi_io_oe   (spi_io_oe),
   .port_owned  (port_owned)
);

// File: tb/mmflash_read_engine_test.sv
module mmflash_read_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_setup = '0;
   logic        cfg_map_sel = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_ready, rsp_valid, spi_sclk, spi_cs_n, port_owned;
   logic [31:0] rsp_data;
   logic [3:0]  spi_io_out, spi_io_oe;
   logic [3:0]  spi_io_in = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   mmflash_read_engine #(.ADDR_W(24), .QUAD_EN(1'b1)) uut (.*);

   // Bench view of the framing
   int          m_n, m_dmy, m_pre, m_tot;
   bit          m_quad;
   logic [7:0]  m_op;
   logic [31:0] m_addr;

   // Flash model state
   int          fl_edges;
   logic [7:0]  fl_op;
   logic [31:0] fl_ad;
   bit          fl_oe_bad;

   function automatic logic [7:0] fbyte(input logic [31:0] a);
      logic [31:0] t;
      t = a * 32'd13 + (a >> 8);
      return t[7:0] ^ 8'hA5;
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] a);
      return {fbyte(a + 3), fbyte(a + 2), fbyte(a + 1), fbyte(a)};
   endfunction

   always @(negedge spi_cs_n) begin
      fl_edges  = 0;
      fl_op     = '0;
      fl_ad     = '0;
      fl_oe_bad = 1'b0;
   end

   always @(posedge spi_sclk) if (!spi_cs_n) begin
      if (fl_edges < 8)                fl_op = {fl_op[6:0], spi_io_out[0]};
      else if (fl_edges < 8 + 8*m_n)   fl_ad = {fl_ad[30:0], spi_io_out[0]};
      if (fl_edges >= m_pre) begin
         if (m_quad && spi_io_oe != 4'b0000) fl_oe_bad = 1'b1;
         if (!m_quad && spi_io_oe != 4'b0001) fl_oe_bad = 1'b1;
      end else if (spi_io_oe != 4'b0001) fl_oe_bad = 1'b1;
      fl_edges++;
   end

   always @(negedge spi_sclk) begin
      #1;
      if (!spi_cs_n && fl_edges >= m_pre) begin
         int k;
         logic [7:0] b;
         k = fl_edges - m_pre;
         if (m_quad) begin
            b = fbyte(m_addr + 32'(k / 2));
            spi_io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
         end else begin
            b = fbyte(m_addr + 32'(k / 8));
            spi_io_in = {2'b00, b[7 - (k % 8)], 1'b0};
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [7:0] op, input logic [1:0] nf, input logic [1:0] df,
                          input logic [4:0] ex, input logic [1:0] rt);
      @(negedge clk);
      cfg_setup = {3'b000, ex, 8'h02, 2'b00, rt, df, nf, op};
      m_op   = op;
      m_n    = int'(nf) + 1;
      m_dmy  = 8 * int'(df) + int'(ex);
      m_quad = (rt == 2'b11);
      m_pre  = 8 + 8 * m_n + m_dmy;
      m_tot  = m_pre + (m_quad ? 8 : 32);
   endtask

   // mode 0 plain, 1 change setup mid-sequence, 2 clear switch mid-sequence
   task automatic do_read(input logic [23:0] a, input int mode);
      logic [63:0] mask;
      mask   = (64'd1 << (8 * m_n)) - 1;
      m_addr = 32'({40'd0, a} & mask);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 cs low after accept", spi_cs_n, 1'b0);
      if (mode == 1) begin
         repeat (6) @(negedge clk);
         cfg_setup = ~cfg_setup;
      end
      if (mode == 2) begin
         repeat (6) @(negedge clk);
         cfg_map_sel = 1'b0;
         @(negedge clk);
         chk("R9 owned while running", {port_owned, spi_cs_n}, 2'b10);
      end
      while (!rsp_valid) @(negedge clk);
      chk("R2 opcode", fl_op, m_op);
      chk("R3 address", fl_ad, m_addr);
      chk("R4 clock count", 64'(fl_edges), 64'(m_tot));
      chk("R5 R6 data word", rsp_data, exp_word(m_addr));
      chk("R5 output enables", fl_oe_bad, 1'b0);
      chk("R7 cs high at response", spi_cs_n, 1'b1);
      @(negedge clk);
      chk("R7 single pulse", rsp_valid, 1'b0);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd5171));
      set_cfg(8'h03, 2'd2, 2'd0, 5'd0, 2'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset pins", {spi_cs_n, spi_sclk, spi_io_oe}, {1'b1, 1'b0, 4'b0000});
      chk("R1 reset ready", {req_ready, rsp_valid, port_owned}, 3'b000);

      // R1: request waits while the register engine owns the port
      req_valid = 1'b1;
      req_addr  = 24'h012345;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (req_ready || !spi_cs_n) chk("R1 held while unmapped", {req_ready, spi_cs_n}, 2'b01);
      end
      chk("R1 no sequence started", {req_ready, spi_cs_n, port_owned}, 3'b010);
      req_valid = 1'b0;
      cfg_map_sel = 1'b1;
      do_read(24'h012345, 0);

      // Directed framings
      set_cfg(8'h0B, 2'd2, 2'd1, 5'd0, 2'd0);
      do_read(24'hABCDEF, 0);
      set_cfg(8'h6B, 2'd2, 2'd1, 5'd0, 2'd3);
      do_read(24'h00FFFC, 0);
      set_cfg(8'hC3, 2'd0, 2'd3, 5'd31, 2'd3);
      do_read(24'hFFFFFF, 0);
      set_cfg(8'h5A, 2'd3, 2'd0, 5'd3, 2'd1);
      do_read(24'h800001, 0);

      // R8: setup change in the middle of a sequence
      set_cfg(8'h6B, 2'd2, 2'd0, 5'd4, 2'd3);
      do_read(24'h123456, 1);
      set_cfg(8'h03, 2'd1, 2'd0, 5'd0, 2'd0);
      do_read(24'h00BEEF, 1);

      // R9: switch cleared mid-sequence, sequence completes
      set_cfg(8'h03, 2'd2, 2'd0, 5'd0, 2'd0);
      do_read(24'h345678, 2);
      chk("R9 released after finish", {port_owned, req_ready}, 2'b00);
      cfg_map_sel = 1'b1;

      // Random framings
      for (int i = 0; i < 40; i++) begin
         set_cfg(8'($urandom), 2'($urandom), 2'($urandom), 5'($urandom), 2'($urandom));
         do_read(24'($urandom), 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule